// File: doc/BRIEF.md
# Serial Control Port Register Decoder

This block receives settings over a three-wire, write-only control port made of a control clock, a phase line and a data line, and turns them into the control fields of an audio converter. The phase line chooses between two phases. While it is low, the port expects an address byte. That byte carries a 6-bit device address, which this instance must match, and a 2-bit bank code. While the phase line is high, the port accepts data bytes. Each data byte names one register of the selected bank in its top two bits and carries the value in its lower six bits.

All three lines are expected to be already synchronised to the system clock. The block oversamples them, finds the rising edges of the control clock and shifts in one bit per edge, least significant bit first. A register changes only when a whole byte has arrived. Once an address has been matched, it stays in force for any number of data bytes until the next address byte. Besides the raw fields, the block presents the volume as a decoded attenuation in dB and a full-mute flag.

Top module: `ctl_port_decoder`

## Requirements
- R1: A byte is shifted in least significant bit first, one bit per rising edge of `ser_clk`, and it has an effect only after its eighth bit. A partial byte changes no output.
- R2: `ser_mode` low marks the address phase and high marks the data phase. Any change of `ser_mode` discards the bits gathered so far, so the next rising edge starts a new byte.
- R3: The port is selected only by an address byte whose bits 7..2 equal the `DEV_ADDR` parameter (default 000101). Any other address deselects the port, and data bytes then change no field.
- R4: Address bits 1..0 pick the bank: 01 is the status bank and 11 is the data bank. With 00 or 10, data bytes write nothing.
- R5: A matched address and its bank stay in force across any number of data bytes, until the next address byte.
- R6: In the status bank, a data byte with bits 7..6 = 00 loads `clk_ratio` from bits 5..4 (00 = 512fs, 01 = 384fs, 10 = 256fs) and `in_format` from bits 3..1 (000 = I2S, 001/010/011 = LSB-justified 16/18/20-bit, 100 = MSB-justified). Bytes with other bits 7..6 values are dropped.
- R7: In the data bank, a data byte with bits 7..6 = 00 loads `volume` from bits 5..0.
- R8: In the data bank, a data byte with bits 7..6 = 10 loads `deemph` from bits 4..3 (00 = off, 01 = 32 kHz, 10 = 44.1 kHz, 11 = 48 kHz) and `mute` from bit 2. Bits 7..6 = 01 or 11 are dropped.
- R9: `vol_atten` is 0 for volume codes 0 and 1, is code−1 for codes 2 to 61, and saturates at 60 for codes 62 and 63. `vol_kill` is high only for code 63.
- R10: After reset, every field is zero and the port is deselected, so data bytes sent before any address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ser_clk | input | 1 | Control clock (synchronised); bits are taken on its rising edge |
| ser_mode | input | 1 | Phase line: 0 = address phase, 1 = data phase |
| ser_data | input | 1 | Serial data, LSB first |
| clk_ratio | output | 2 | System clock ratio code |
| in_format | output | 3 | Serial audio input format code |
| volume | output | 6 | Raw volume code |
| deemph | output | 2 | De-emphasis code |
| mute | output | 1 | Soft mute request |
| vol_atten | output | 6 | Volume attenuation in dB (0..60) |
| vol_kill | output | 1 | Volume at minus infinity |

## Verification
The bench checks bit order by writing volume values whose reversed image would land on a different sub-address. A design that shifted MSB first would therefore write de-emphasis instead of volume. It leaves bytes unfinished and toggles the phase line in the middle of one. A counter that was not cleared would then commit a byte built from stale bits, and a design that committed partial bytes would move the volume early. It sends data after a wrong address, after the unused banks and before any address following reset, and writes the reserved sub-addresses. A decoder that did not enforce selection, or that did not drop reserved writes, would corrupt the fields. The volume map is probed at codes 0, 1, 61, 62 and 63, where an off-by-one or a missing saturation shows up directly.

// File: rtl/ctlp_pkg.sv
package ctlp_pkg;
  localparam int BYTE_W  = 8;
  localparam int ADDR_W  = 6;
  localparam int BANK_W  = BYTE_W - ADDR_W;
  localparam int SUB_W   = 2;
  localparam int VAL_W   = BYTE_W - SUB_W;
  localparam int CNT_W   = $clog2(BYTE_W);

  typedef enum logic [BANK_W-1:0] {
    BANK_UNUSED0 = 2'b00,
    BANK_STATUS  = 2'b01,
    BANK_UNUSED2 = 2'b10,
    BANK_DATA    = 2'b11
  } bank_e;

  localparam logic [SUB_W-1:0] SUB_MAIN = 2'b00;
  localparam logic [SUB_W-1:0] SUB_FILT = 2'b10;

  typedef struct packed {
    logic [1:0]       clk_ratio;
    logic [2:0]       in_format;
    logic [VAL_W-1:0] volume;
    logic [1:0]       deemph;
    logic             mute;
  } ctl_fields_t;
endpackage

// File: rtl/ctlp_edge.sv
module ctlp_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_clk,
  input  logic ser_mode,
  output logic clk_rise,
  output logic mode_chg
);
  logic sclk_q, sclk_d;
  logic mode_q, mode_d;

  always_comb begin
    sclk_d   = ser_clk;
    mode_d   = ser_mode;
    clk_rise = ser_clk & ~sclk_q;
    mode_chg = ser_mode ^ mode_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      mode_q <= 1'b0;
    end else begin
      sclk_q <= sclk_d;
      mode_q <= mode_d;
    end
  end
endmodule

// File: rtl/ctlp_shifter.sv
module ctlp_shifter
  import ctlp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_rise,
  input  logic              mode_chg,
  input  logic              ser_mode,
  input  logic              ser_data,
  output logic              byte_vld,
  output logic [BYTE_W-1:0] byte_val,
  output logic              byte_is_data
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic [CNT_W-1:0]  cnt_q, cnt_d, cnt_base;
  logic [BYTE_W-1:0] shr_q, shr_d;
  logic [BYTE_W-1:0] byte_q, byte_d;
  logic              vld_q, vld_d;
  logic              ph_q, ph_d;

  always_comb begin
    cnt_base = mode_chg ? '0 : cnt_q;
    cnt_d    = cnt_base;
    shr_d    = shr_q;
    byte_d   = byte_q;
    ph_d     = ph_q;
    vld_d    = 1'b0;
    if (clk_rise) begin
      shr_d = {ser_data, shr_q[BYTE_W-1:1]};
      if (cnt_base == LAST_BIT) begin
        cnt_d  = '0;
        vld_d  = 1'b1;
        byte_d = shr_d;
        ph_d   = ser_mode;
      end else begin
        cnt_d = cnt_base + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      shr_q  <= '0;
      byte_q <= '0;
      vld_q  <= 1'b0;
      ph_q   <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      shr_q <= shr_d;
      vld_q <= vld_d;
      if (vld_d) begin
        byte_q <= byte_d;
        ph_q   <= ph_d;
      end
    end
  end

  assign byte_vld     = vld_q;
  assign byte_val     = byte_q;
  assign byte_is_data = ph_q;
endmodule

// File: rtl/ctlp_addr.sv
module ctlp_addr
  import ctlp_pkg::*;
#(
  parameter logic [ADDR_W-1:0] DEV_ADDR = 6'b000101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_val,
  input  logic              byte_is_data,
  output logic              dev_sel,
  output bank_e             bank
);
  logic  sel_q, sel_d;
  bank_e bank_q, bank_d;
  logic  addr_en;

  always_comb begin
    addr_en = byte_vld & ~byte_is_data;
    sel_d   = (byte_val[BYTE_W-1:BANK_W] == DEV_ADDR);
    bank_d  = bank_e'(byte_val[BANK_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= 1'b0;
      bank_q <= BANK_UNUSED0;
    end else if (addr_en) begin
      sel_q  <= sel_d;
      bank_q <= bank_d;
    end
  end

  assign dev_sel = sel_q;
  assign bank    = bank_q;
endmodule

// File: rtl/ctlp_regfile.sv
module ctlp_regfile
  import ctlp_pkg::*;
#(
  parameter int MAX_ATTEN = 60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_val,
  input  logic              byte_is_data,
  input  logic              dev_sel,
  input  bank_e             bank,
  output ctl_fields_t       fields,
  output logic [VAL_W-1:0]  vol_atten,
  output logic              vol_kill
);
  localparam logic [VAL_W-1:0] VOL_TOP  = {VAL_W{1'b1}};
  localparam logic [VAL_W-1:0] ATT_CAP  = VAL_W'(MAX_ATTEN);
  localparam logic [VAL_W-1:0] VOL_SAT  = VAL_W'(MAX_ATTEN + 1);

  ctl_fields_t      regs_q, regs_d;
  logic             wr_en;
  logic [SUB_W-1:0] sub;
  logic [VAL_W-1:0] val;

  always_comb begin
    wr_en  = byte_vld & byte_is_data & dev_sel;
    sub    = byte_val[BYTE_W-1:VAL_W];
    val    = byte_val[VAL_W-1:0];
    regs_d = regs_q;
    if (wr_en) begin
      unique case (bank)
        BANK_STATUS: begin
          if (sub == SUB_MAIN) begin
            regs_d.clk_ratio = val[5:4];
            regs_d.in_format = val[3:1];
          end
        end
        BANK_DATA: begin
          if (sub == SUB_MAIN) begin
            regs_d.volume = val;
          end else if (sub == SUB_FILT) begin
            regs_d.deemph = val[4:3];
            regs_d.mute   = val[2];
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs_q <= '0;
    end else if (wr_en) begin
      regs_q <= regs_d;
    end
  end

  always_comb begin
    if (regs_q.volume <= VAL_W'(1)) begin
      vol_atten = '0;
    end else if (regs_q.volume >= VOL_SAT) begin
      vol_atten = ATT_CAP;
    end else begin
      vol_atten = regs_q.volume - 1'b1;
    end
    vol_kill = (regs_q.volume == VOL_TOP);
  end

  assign fields = regs_q;
endmodule

// File: rtl/ctl_port_decoder.sv
module ctl_port_decoder
  import ctlp_pkg::*;
#(
  parameter logic [ADDR_W-1:0] DEV_ADDR  = 6'b000101,
  parameter int                MAX_ATTEN = 60
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_clk,
  input  logic             ser_mode,
  input  logic             ser_data,
  output logic [1:0]       clk_ratio,
  output logic [2:0]       in_format,
  output logic [VAL_W-1:0] volume,
  output logic [1:0]       deemph,
  output logic             mute,
  output logic [VAL_W-1:0] vol_atten,
  output logic             vol_kill
);
  logic              rst_meta_q, rst_sync_q;
  logic              clk_rise, mode_chg;
  logic              byte_vld, byte_is_data;
  logic [BYTE_W-1:0] byte_val;
  logic              dev_sel;
  bank_e             bank;
  ctl_fields_t       fields;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  ctlp_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .ser_clk  (ser_clk),
    .ser_mode (ser_mode),
    .clk_rise (clk_rise),
    .mode_chg (mode_chg)
  );

  ctlp_shifter u_shift (
    .clk          (clk),
    .rst_n        (rst_sync_q),
    .clk_rise     (clk_rise),
    .mode_chg     (mode_chg),
    .ser_mode     (ser_mode),
    .ser_data     (ser_data),
    .byte_vld     (byte_vld),
    .byte_val     (byte_val),
    .byte_is_data (byte_is_data)
  );

  ctlp_addr #(.DEV_ADDR(DEV_ADDR)) u_addr (
    .clk          (clk),
    .rst_n        (rst_sync_q),
    .byte_vld     (byte_vld),
    .byte_val     (byte_val),
    .byte_is_data (byte_is_data),
    .dev_sel      (dev_sel),
    .bank         (bank)
  );

  ctlp_regfile #(.MAX_ATTEN(MAX_ATTEN)) u_regs (
    .clk          (clk),
    .rst_n        (rst_sync_q),
    .byte_vld     (byte_vld),
    .byte_val     (byte_val),
    .byte_is_data (byte_is_data),
    .dev_sel      (dev_sel),
    .bank         (bank),
    .fields       (fields),
    .vol_atten    (vol_atten),
    .vol_kill     (vol_kill)
  );

  assign clk_ratio = fields.clk_ratio;
  assign in_format = fields.in_format;
  assign volume    = fields.volume;
  assign deemph    = fields.deemph;
  assign mute      = fields.mute;
endmodule

// File: rtl/ctlp_checker.sv
module ctlp_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       ser_mode,
  input logic       byte_vld,
  input logic       dev_sel,
  input logic [1:0] clk_ratio,
  input logic [2:0] in_format,
  input logic [5:0] volume,
  input logic [1:0] deemph,
  input logic       mute,
  input logic [5:0] vol_atten,
  input logic       vol_kill
);
  logic [13:0] all_fields;
  assign all_fields = {clk_ratio, in_format, volume, deemph, mute};

  // R1: fields move only right after a completed byte
  assert_regs_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(byte_vld) |-> $stable(all_fields));

  // R2: a phase change never completes a byte on the next cycle
  assert_mode_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_mode != $past(ser_mode)) |=> !byte_vld);

  // R3: a deselected port leaves every field alone
  assert_deselect_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(dev_sel) |-> $stable(all_fields));

  // R9: attenuation stays within its range
  assert_atten_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    vol_atten <= 6'd60);

  // R9: full mute implies saturated attenuation
  assert_kill_sat_R9: assert property (@(posedge clk) disable iff (!rst_n)
    vol_kill |-> (vol_atten == 6'd60));
endmodule

bind ctl_port_decoder ctlp_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ser_mode  (ser_mode),
  .byte_vld  (byte_vld),
  .dev_sel   (dev_sel),
  .clk_ratio (clk_ratio),
  .in_format (in_format),
  .volume    (volume),
  .deemph    (deemph),
  .mute      (mute),
  .vol_atten (vol_atten),
  .vol_kill  (vol_kill)
);

// File: tb/test_ctl_port_decoder.sv
module test_ctl_port_decoder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ser_clk = 1'b0;
  logic       ser_mode = 1'b0;
  logic       ser_data = 1'b0;
  logic [1:0] clk_ratio;
  logic [2:0] in_format;
  logic [5:0] volume;
  logic [1:0] deemph;
  logic       mute;
  logic [5:0] vol_atten;
  logic       vol_kill;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ctl_port_decoder i_ctl_port_decoder (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_mode(ser_mode),
    .ser_data(ser_data), .clk_ratio(clk_ratio), .in_format(in_format),
    .volume(volume), .deemph(deemph), .mute(mute),
    .vol_atten(vol_atten), .vol_kill(vol_kill)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_mode(input logic m);
    if (ser_mode != m) begin
      ser_mode = m;
      tick(3);
    end
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      ser_data = b[i];
      tick(3);
      ser_clk = 1'b1;
      tick(3);
      ser_clk = 1'b0;
    end
    tick(6);
  endtask

  task automatic send_byte(input logic m, input logic [7:0] b);
    set_mode(m);
    send_bits(b, 8);
  endtask

  task automatic t_reset;
    chk("R10 clk_ratio reset", clk_ratio, 0);
    chk("R10 in_format reset", in_format, 0);
    chk("R10 volume reset", volume, 0);
    chk("R10 deemph/mute reset", {deemph, mute}, 0);
    send_byte(1'b1, 8'h05);
    chk("R10 deselected after reset", volume, 0);
  endtask

  task automatic t_status;
    send_byte(1'b0, 8'h15);
    send_byte(1'b1, 8'h28);
    chk("R6 clk_ratio 256fs", clk_ratio, 2);
    chk("R6 in_format MSB-justified", in_format, 4);
    send_byte(1'b1, 8'h7E);
    chk("R6 reserved sub dropped ratio", clk_ratio, 2);
    chk("R6 reserved sub dropped format", in_format, 4);
  endtask

  task automatic t_data;
    send_byte(1'b0, 8'h17);
    send_byte(1'b1, 8'h05);
    chk("R7 R1 volume LSB first", volume, 5);
    chk("R9 atten code 5", vol_atten, 4);
    send_byte(1'b1, 8'h94);
    chk("R8 deemph 44.1", deemph, 2);
    chk("R8 mute set", mute, 1);
    chk("R5 volume kept, still selected", volume, 5);
    send_byte(1'b1, 8'h7F);
    send_byte(1'b1, 8'hFF);
    chk("R8 reserved subs dropped volume", volume, 5);
    chk("R8 reserved subs dropped deemph", {deemph, mute}, 5);
    chk("R6 data bank leaves status", clk_ratio, 2);
  endtask

  task automatic t_atten;
    send_byte(1'b1, 8'h00);
    chk("R9 code0 atten", vol_atten, 0);
    send_byte(1'b1, 8'h01);
    chk("R9 code1 atten", vol_atten, 0);
    send_byte(1'b1, 8'h3D);
    chk("R9 code61 atten", vol_atten, 60);
    chk("R9 code61 not kill", vol_kill, 0);
    send_byte(1'b1, 8'h3E);
    chk("R9 code62 atten", vol_atten, 60);
    send_byte(1'b1, 8'h3F);
    chk("R9 code63 kill", vol_kill, 1);
    chk("R9 code63 atten", vol_atten, 60);
  endtask

  task automatic t_addr;
    send_byte(1'b0, 8'h27);
    send_byte(1'b1, 8'h0A);
    chk("R3 wrong address ignored", volume, 63);
    send_byte(1'b0, 8'h14);
    send_byte(1'b1, 8'h00);
    chk("R4 bank 00 writes nothing", volume, 63);
    chk("R4 bank 00 status untouched", clk_ratio, 2);
    send_byte(1'b0, 8'h16);
    send_byte(1'b1, 8'h0C);
    chk("R4 bank 10 writes nothing", volume, 63);
  endtask

  task automatic t_partial;
    send_byte(1'b0, 8'h17);
    set_mode(1'b1);
    send_bits(8'h3C, 5);
    chk("R1 partial byte no effect", volume, 63);
    set_mode(1'b0);
    set_mode(1'b1);
    send_bits(8'h09, 8);
    chk("R2 mode change restarts byte", volume, 9);
    send_bits(8'hFF, 3);
    set_mode(1'b0);
    set_mode(1'b1);
    send_bits(8'h12, 8);
    chk("R2 stale bits discarded", volume, 18);
    chk("R2 stale bits deemph kept", deemph, 2);
  endtask

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(10);
    t_reset();
    t_status();
    t_data();
    t_atten();
    t_addr();
    t_partial();
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule